// File: doc/BRIEF.md
# PHY Presence Scan Arbiter

This block sits between software-facing management requests and a single MDIO frame engine. While scanning is enabled, it polls every PHY address in turn in the background. Each poll reads the basic status register. The answers are kept in two bitmaps. The presence map records which addresses acknowledged. The link map records which of those reported link up. A software request uses the same engine. It is slotted in at the next frame boundary and goes ahead of the next poll, so it waits behind at most one background frame.

Scanning is switched off by dropping the enable level. A frame already handed to the engine still runs to completion and its result is recorded. After that no new poll is issued, and the idle flag rises. Software requests are still served while scanning is off. Raising the enable again resumes polling at the address after the last one polled.

Top module: `phy_scan_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `idle` is 1 (with `scan_en` low), both bitmaps are all zeros, `eng_req` is 0, `usr_ack` is 0, and the scan pointer is at address 0.
- R2: Every background frame is a read (`eng_wr`=0) of register 1 (`eng_reg`=1). Successive background frames target ascending addresses that wrap from 31 to 0. The pointer advances only when a background frame completes.
- R3: When a background frame completes, bit `eng_phy` of `alive_map` takes the value of `eng_ack` for that frame.
- R4: When a background frame completes, bit `eng_phy` of `link_map` is set to `eng_ack` AND `eng_rdata[2]`. A frame with no acknowledge clears both bits, so a link bit is never set while its alive bit is clear.
- R5: Starting from pointer 0, both bitmaps hold the state of all 32 addresses once 32 background frames have completed.
- R6: A software request (`usr_req` held high) is carried to the engine with its own `usr_wr`, `usr_phy`, `usr_reg` and `usr_wdata`. Its completion gives a one-cycle `usr_ack` pulse with `usr_rdata` = `eng_rdata` and `usr_ok` = `eng_ack`. Software frames leave both bitmaps unchanged.
- R7: At a frame boundary, a pending software request wins over the next background poll. At most one background frame is granted between the rise of `usr_req` and the grant of the software frame.
- R8: After a software frame, the background scan continues at the address after the last one it polled.
- R9: When `scan_en` falls while a frame is outstanding, that frame completes and its result is recorded. `idle` rises in the cycle after completion, and no further background frame is requested while `scan_en` stays low.
- R10: When `scan_en` rises again, `idle` falls in the same cycle and background polling restarts.
- R11: `eng_req` and the frame fields hold steady until `eng_gnt`. Only one frame is outstanding at a time, and `eng_req` is low while a frame is in flight.
- R12: Software requests are served while scanning is off, and `idle` stays low while such a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | Background scan enable level |
| idle | output | 1 | Scan stopped, nothing pending or in flight |
| usr_req | input | 1 | Software request, held until `usr_ack` |
| usr_wr | input | 1 | 1 = write, 0 = read |
| usr_phy | input | 5 | Target PHY address |
| usr_reg | input | 5 | Target register |
| usr_wdata | input | 16 | Write data |
| usr_ack | output | 1 | One-cycle completion pulse |
| usr_rdata | output | 16 | Read data of the completed software frame |
| usr_ok | output | 1 | PHY acknowledged the software frame |
| eng_req | output | 1 | Frame request to the engine |
| eng_wr | output | 1 | Frame direction |
| eng_phy | output | 5 | Frame PHY address |
| eng_reg | output | 5 | Frame register |
| eng_wdata | output | 16 | Frame write data |
| eng_gnt | input | 1 | Engine accepted the frame |
| eng_done | input | 1 | Engine finished the frame (one cycle) |
| eng_rdata | input | 16 | Read data, valid with `eng_done` |
| eng_ack | input | 1 | PHY acknowledged, valid with `eng_done` |
| alive_map | output | 32 | Per-address presence bitmap |
| link_map | output | 32 | Per-address link bitmap |

## Verification
The bench issues software requests while polling is active. It counts how many background grants slip in ahead of each request, which would exceed one if the arbiter let the scan win at a boundary. It follows the sequence of polled addresses across the software frames, so a pointer that skipped or repeated an address, or advanced on a software frame, shows up as a broken sequence. It then removes a PHY and turns another PHY's link on. A design that kept a stale link bit for a silent address would be caught at that point. Finally it drops `scan_en` during a frame: a design that aborted the frame, raised `idle` early, or kept polling is caught by the completion count and the quiet window.

// File: rtl/phy_scan_pkg.sv
// Shared types for the PHY presence scan arbiter.
package phy_scan_pkg;
    // Arbiter phases: boundary, request pending at the engine, frame in flight.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_BUSY = 2'd2
    } arb_state_e;
endpackage

// File: rtl/scan_sequencer.sv
// Background address pointer.
// Moves to the next address, wrapping at N_PHY-1, each time a background
// frame completes. Assumes step is a single-cycle pulse.
module scan_sequencer #(
    parameter int N_PHY  = 32,
    localparam int ADDR_W = $clog2(N_PHY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_PHY - 1);

    // Advance the pointer with wrap on every completed poll.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (step)
            addr <= (addr == LAST) ? '0 : addr + 1'b1;
    end
endmodule

// File: rtl/presence_maps.sv
// Per-address presence and link bitmaps.
// On an update pulse, the bit at addr takes the acknowledge, and the link bit
// takes acknowledge AND the reported link level. Assumes addr < N_PHY.
module presence_maps #(
    parameter int N_PHY  = 32,
    localparam int ADDR_W = $clog2(N_PHY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ack,
    input  logic              link_in,
    output logic [N_PHY-1:0]  alive,
    output logic [N_PHY-1:0]  link
);
    for (genvar i = 0; i < N_PHY; i++) begin : g_bit
        // Record the outcome of the poll that targeted address i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                alive[i] <= 1'b0;
                link[i]  <= 1'b0;
            end else if (upd && addr == ADDR_W'(i)) begin
                alive[i] <= ack;
                link[i]  <= ack & link_in;
            end
        end
    end
endmodule

// File: rtl/frame_arbiter.sv
// Frame arbiter and engine handshake.
// At each boundary it picks a pending software request first and the next
// background poll second. It presents the frame until granted and waits for
// done. Assumes usr_req is held until usr_ack and eng_done comes once per grant.
module frame_arbiter
    import phy_scan_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int REG_W      = 5,
    parameter int DATA_W     = 16,
    parameter int STATUS_REG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              usr_req,
    input  logic              usr_wr,
    input  logic [ADDR_W-1:0] usr_phy,
    input  logic [REG_W-1:0]  usr_reg,
    input  logic [DATA_W-1:0] usr_wdata,
    input  logic [ADDR_W-1:0] scan_addr,
    input  logic              eng_gnt,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rdata,
    input  logic              eng_ack,
    output logic              eng_req,
    output logic              eng_wr,
    output logic [ADDR_W-1:0] eng_phy,
    output logic [REG_W-1:0]  eng_reg,
    output logic [DATA_W-1:0] eng_wdata,
    output logic              usr_ack,
    output logic [DATA_W-1:0] usr_rdata,
    output logic              usr_ok,
    output logic              scan_step,
    output logic              idle,
    output logic              at_boundary,
    output logic              in_busy,
    output logic              own_usr
);
    arb_state_e st;
    logic       usr_pend;

    assign usr_pend    = usr_req && !usr_ack;
    assign at_boundary = (st == ST_IDLE);
    assign in_busy     = (st == ST_BUSY);
    assign eng_req     = (st == ST_REQ);
    assign scan_step   = in_busy && eng_done && !own_usr;
    assign idle        = at_boundary && !scan_en && !usr_pend;

    // Phase sequencing and frame field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            own_usr   <= 1'b0;
            eng_wr    <= 1'b0;
            eng_phy   <= '0;
            eng_reg   <= '0;
            eng_wdata <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (usr_pend) begin
                        st        <= ST_REQ;
                        own_usr   <= 1'b1;
                        eng_wr    <= usr_wr;
                        eng_phy   <= usr_phy;
                        eng_reg   <= usr_reg;
                        eng_wdata <= usr_wdata;
                    end else if (scan_en) begin
                        st        <= ST_REQ;
                        own_usr   <= 1'b0;
                        eng_wr    <= 1'b0;
                        eng_phy   <= scan_addr;
                        eng_reg   <= REG_W'(STATUS_REG);
                        eng_wdata <= '0;
                    end
                end
                ST_REQ:  if (eng_gnt)  st <= ST_BUSY;
                ST_BUSY: if (eng_done) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Return path for software frames: one-cycle acknowledge plus result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usr_ack   <= 1'b0;
            usr_rdata <= '0;
            usr_ok    <= 1'b0;
        end else begin
            usr_ack <= in_busy && eng_done && own_usr;
            if (in_busy && eng_done && own_usr) begin
                usr_rdata <= eng_rdata;
                usr_ok    <= eng_ack;
            end
        end
    end
endmodule

// File: rtl/phy_scan_arbiter.sv
// PHY presence scan arbiter top.
// Shares one MDIO frame engine between background status polling and
// software requests, and keeps the per-address presence and link bitmaps.
// Assumes a single engine with a req/gnt/done handshake.
module phy_scan_arbiter #(
    parameter int N_PHY      = 32,
    parameter int REG_W      = 5,
    parameter int DATA_W     = 16,
    parameter int STATUS_REG = 1,
    parameter int LINK_BIT   = 2,
    localparam int ADDR_W    = $clog2(N_PHY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    output logic              idle,
    input  logic              usr_req,
    input  logic              usr_wr,
    input  logic [ADDR_W-1:0] usr_phy,
    input  logic [REG_W-1:0]  usr_reg,
    input  logic [DATA_W-1:0] usr_wdata,
    output logic              usr_ack,
    output logic [DATA_W-1:0] usr_rdata,
    output logic              usr_ok,
    output logic              eng_req,
    output logic              eng_wr,
    output logic [ADDR_W-1:0] eng_phy,
    output logic [REG_W-1:0]  eng_reg,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_gnt,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rdata,
    input  logic              eng_ack,
    output logic [N_PHY-1:0]  alive_map,
    output logic [N_PHY-1:0]  link_map
);
    logic [ADDR_W-1:0] scan_addr;
    logic              scan_step;
    logic              at_boundary;
    logic              in_busy;
    logic              own_usr;

    scan_sequencer #(.N_PHY(N_PHY)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .step (scan_step),
        .addr (scan_addr)
    );

    frame_arbiter #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W), .STATUS_REG(STATUS_REG)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_en    (scan_en),
        .usr_req    (usr_req),
        .usr_wr     (usr_wr),
        .usr_phy    (usr_phy),
        .usr_reg    (usr_reg),
        .usr_wdata  (usr_wdata),
        .scan_addr  (scan_addr),
        .eng_gnt    (eng_gnt),
        .eng_done   (eng_done),
        .eng_rdata  (eng_rdata),
        .eng_ack    (eng_ack),
        .eng_req    (eng_req),
        .eng_wr     (eng_wr),
        .eng_phy    (eng_phy),
        .eng_reg    (eng_reg),
        .eng_wdata  (eng_wdata),
        .usr_ack    (usr_ack),
        .usr_rdata  (usr_rdata),
        .usr_ok     (usr_ok),
        .scan_step  (scan_step),
        .idle       (idle),
        .at_boundary(at_boundary),
        .in_busy    (in_busy),
        .own_usr    (own_usr)
    );

    presence_maps #(.N_PHY(N_PHY)) u_maps (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (scan_step),
        .addr   (eng_phy),
        .ack    (eng_ack),
        .link_in(eng_rdata[LINK_BIT]),
        .alive  (alive_map),
        .link   (link_map)
    );
endmodule

// File: rtl/phy_scan_arbiter_chk.sv
// Property checker for phy_scan_arbiter, attached with bind below.
// Observes ports plus the arbiter phase flags brought out at the top.
module phy_scan_arbiter_chk #(
    parameter int N_PHY  = 32,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(N_PHY)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usr_req,
    input logic              usr_ack,
    input logic              idle,
    input logic              eng_req,
    input logic              eng_gnt,
    input logic              eng_done,
    input logic              eng_ack,
    input logic              eng_wr,
    input logic [ADDR_W-1:0] eng_phy,
    input logic [REG_W-1:0]  eng_reg,
    input logic [DATA_W-1:0] eng_wdata,
    input logic [N_PHY-1:0]  alive_map,
    input logic [N_PHY-1:0]  link_map,
    input logic              at_boundary,
    input logic              in_busy,
    input logic              own_usr
);
    // R11: a frame offer stays put with its fields until granted.
    a_r11_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_gnt) |=> (eng_req && $stable({eng_wr, eng_phy, eng_reg, eng_wdata})));

    // R11: no new offer while a frame is in flight.
    a_r11_single_frame: assert property (@(posedge clk) disable iff (!rst_n)
        in_busy |-> !eng_req);

    // R7: software wins at a boundary.
    a_r7_user_first: assert property (@(posedge clk) disable iff (!rst_n)
        (at_boundary && usr_req && !usr_ack) |=> (eng_req && own_usr));

    // R9: once idle with no software request, nothing is offered next cycle.
    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !usr_req) |=> !eng_req);

    // R6: the completion strobe lasts a single cycle.
    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        usr_ack |=> !usr_ack);

    // R6: software frames leave the bitmaps alone.
    a_r6_maps_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_busy && eng_done && own_usr) |=> ($stable(alive_map) && $stable(link_map)));

    // R4: a silent address loses both bits.
    a_r4_nack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_busy && eng_done && !own_usr && !eng_ack) |=>
        (!alive_map[$past(eng_phy)] && !link_map[$past(eng_phy)]));

    // R4: a link bit never stands without its alive bit.
    a_r4_link_within_alive: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_map & ~alive_map) == '0));
endmodule

bind phy_scan_arbiter phy_scan_arbiter_chk #(
    .N_PHY(N_PHY), .REG_W(REG_W), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .usr_req    (usr_req),
    .usr_ack    (usr_ack),
    .idle       (idle),
    .eng_req    (eng_req),
    .eng_gnt    (eng_gnt),
    .eng_done   (eng_done),
    .eng_ack    (eng_ack),
    .eng_wr     (eng_wr),
    .eng_phy    (eng_phy),
    .eng_reg    (eng_reg),
    .eng_wdata  (eng_wdata),
    .alive_map  (alive_map),
    .link_map   (link_map),
    .at_boundary(at_boundary),
    .in_busy    (in_busy),
    .own_usr    (own_usr)
);

// File: tb/phy_scan_arbiter_bench.sv
module phy_scan_arbiter_bench;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_en = 1'b0;
    logic        idle;
    logic        usr_req = 1'b0;
    logic        usr_wr = 1'b0;
    logic [4:0]  usr_phy = '0;
    logic [4:0]  usr_reg = '0;
    logic [15:0] usr_wdata = '0;
    logic        usr_ack;
    logic [15:0] usr_rdata;
    logic        usr_ok;
    logic        eng_req;
    logic        eng_wr;
    logic [4:0]  eng_phy;
    logic [4:0]  eng_reg;
    logic [15:0] eng_wdata;
    logic        eng_gnt = 1'b0;
    logic        eng_done = 1'b0;
    logic [15:0] eng_rdata = '0;
    logic        eng_ack = 1'b0;
    logic [31:0] alive_map;
    logic [31:0] link_map;

    always #5 clk = ~clk;

    phy_scan_arbiter u_phy_scan_arbiter (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .idle(idle),
        .usr_req(usr_req), .usr_wr(usr_wr), .usr_phy(usr_phy), .usr_reg(usr_reg),
        .usr_wdata(usr_wdata), .usr_ack(usr_ack), .usr_rdata(usr_rdata), .usr_ok(usr_ok),
        .eng_req(eng_req), .eng_wr(eng_wr), .eng_phy(eng_phy), .eng_reg(eng_reg),
        .eng_wdata(eng_wdata), .eng_gnt(eng_gnt), .eng_done(eng_done),
        .eng_rdata(eng_rdata), .eng_ack(eng_ack), .alive_map(alive_map), .link_map(link_map)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // PHY population model: presence, link level, register contents.
    logic [31:0] present = 32'h8001_0425;
    logic [31:0] linkup  = 32'h0001_0021;
    logic [15:0] regs [32][32];

    // Engine model state and observations.
    bit         usr_pending = 1'b0;
    int         defer_cnt = 0;
    bit         usr_seen = 1'b0;
    int         scan_done_cnt = 0;
    int         seq_err = 0;
    bit         have_prev = 1'b0;
    logic [4:0] prev_addr = '0;

    // Engine: grants offers on the falling edge, completes LAT cycles later.
    initial begin
        bit          busy = 1'b0;
        bit          cur_scan = 1'b0;
        int          cnt = 0;
        logic        f_wr = 1'b0;
        logic [4:0]  f_phy = '0;
        logic [4:0]  f_reg = '0;
        logic [15:0] f_wd = '0;
        for (int p = 0; p < 32; p++)
            for (int r = 0; r < 32; r++)
                regs[p][r] = {3'b101, 5'(r), 5'(p), 3'b011};
        forever begin
            @(negedge clk);
            eng_gnt  = 1'b0;
            eng_done = 1'b0;
            if (busy) begin
                cnt--;
                if (cnt == 0) begin
                    busy = 1'b0;
                    eng_done = 1'b1;
                    if (!present[f_phy]) begin
                        eng_ack = 1'b0;
                        eng_rdata = 16'hFFFF;
                    end else begin
                        eng_ack = 1'b1;
                        if (f_wr) begin
                            if (f_reg != 5'd1) regs[f_phy][f_reg] = f_wd;
                            eng_rdata = 16'hFFFF;
                        end else if (f_reg == 5'd1)
                            eng_rdata = 16'h7809 | {13'd0, linkup[f_phy], 2'b00};
                        else
                            eng_rdata = regs[f_phy][f_reg];
                    end
                    if (cur_scan) scan_done_cnt++;
                end
            end else if (eng_req) begin
                eng_gnt = 1'b1;
                busy = 1'b1;
                cnt = LAT;
                f_wr = eng_wr; f_phy = eng_phy; f_reg = eng_reg; f_wd = eng_wdata;
                cur_scan = !(usr_pending && eng_wr == usr_wr && eng_phy == usr_phy && eng_reg == usr_reg);
                if (cur_scan) begin
                    // R2/R8: background polls are status reads in ascending wrapping order.
                    if (eng_wr || eng_reg != 5'd1) seq_err++;
                    if (have_prev && eng_phy != prev_addr + 5'd1) seq_err++;
                    have_prev = 1'b1;
                    prev_addr = eng_phy;
                    if (usr_pending && !usr_seen) defer_cnt++;
                end else
                    usr_seen = 1'b1;
            end
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Software request vectors: {wr, phy, reg, wdata, exp_rdata, exp_ok, chk_rdata}.
    localparam logic [44:0] VEC [8] = '{
        {1'b0, 5'd5,  5'd2,  16'h0000, 16'hA22B, 1'b1, 1'b1},
        {1'b0, 5'd3,  5'd2,  16'h0000, 16'hFFFF, 1'b0, 1'b1},
        {1'b1, 5'd10, 5'd4,  16'h1234, 16'h0000, 1'b1, 1'b0},
        {1'b0, 5'd10, 5'd4,  16'h0000, 16'h1234, 1'b1, 1'b1},
        {1'b0, 5'd31, 5'd0,  16'h0000, 16'hA0FB, 1'b1, 1'b1},
        {1'b1, 5'd7,  5'd9,  16'hBEEF, 16'h0000, 1'b0, 1'b0},
        {1'b0, 5'd7,  5'd9,  16'h0000, 16'hFFFF, 1'b0, 1'b1},
        {1'b0, 5'd16, 5'd31, 16'h0000, 16'hBF83, 1'b1, 1'b1}
    };

    task automatic run_user(input logic [44:0] v, output int waited);
        usr_wr = v[44]; usr_phy = v[43:39]; usr_reg = v[38:34]; usr_wdata = v[33:18];
        defer_cnt = 0; usr_seen = 1'b0; usr_pending = 1'b1;
        usr_req = 1'b1;
        waited = 0;
        while (!usr_ack && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        usr_req = 1'b0;
        usr_pending = 1'b0;
    endtask

    task automatic wait_scans(input int n);
        int target;
        target = scan_done_cnt + n;
        for (int k = 0; k < 2000 && scan_done_cnt < target; k++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int         w;
        int         c0;
        logic [4:0] last;
        bit         req_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1 idle", 32'(idle), 32'd1);
        check("R1 alive_map", alive_map, 32'd0);
        check("R1 link_map", link_map, 32'd0);
        check("R1 eng_req/usr_ack", {30'd0, eng_req, usr_ack}, 32'd0);

        // R10/R5: enable, then one full sweep fills both maps.
        scan_en = 1'b1;
        #1 check("R10 idle falls with enable", 32'(idle), 32'd0);
        wait_scans(32);
        check("R5 R3 alive after sweep", alive_map, present);
        check("R5 R4 link after sweep", link_map, present & linkup);

        // R6/R7: software requests interleaved with polling.
        foreach (VEC[i]) begin
            run_user(VEC[i], w);
            check($sformatf("R6 ack seen vec%0d", i), 32'(usr_ack), 32'd1);
            check($sformatf("R6 usr_ok vec%0d", i), 32'(usr_ok), 32'(VEC[i][1]));
            if (VEC[i][0]) check($sformatf("R6 usr_rdata vec%0d", i), 32'(usr_rdata), 32'(VEC[i][17:2]));
            check($sformatf("R7 deferral vec%0d", i), 32'(defer_cnt > 1), 32'd0);
            @(negedge clk);
        end
        check("R6 maps kept across software frames", alive_map, present);

        // R3/R4: a PHY vanishes, another gains link.
        present[16] = 1'b0;
        linkup[2]   = 1'b1;
        wait_scans(33);
        check("R3 alive after change", alive_map, 32'h8000_0425);
        check("R4 link after change (no-ack clears)", link_map, 32'h0000_0025);

        // R9: disable while a poll is offered; it completes, then idle.
        while (!eng_req) @(negedge clk);
        last = eng_phy;
        c0 = scan_done_cnt;
        scan_en = 1'b0;
        for (int k = 0; k < 50 && !idle; k++) @(negedge clk);
        check("R9 idle after drain", 32'(idle), 32'd1);
        check("R9 in-flight frame completed once", 32'(scan_done_cnt - c0), 32'd1);
        check("R9 drained result recorded", 32'(alive_map[last]), 32'(present[last]));
        req_seen = 1'b0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (eng_req) req_seen = 1'b1;
        end
        check("R9 no polling while disabled", {31'd0, req_seen}, 32'd0);

        // R12: software access with scanning off.
        usr_wr = 1'b0; usr_phy = 5'd5; usr_reg = 5'd2; usr_wdata = '0;
        usr_pending = 1'b1; defer_cnt = 0; usr_seen = 1'b0;
        usr_req = 1'b1;
        #1 check("R12 idle low while pending", 32'(idle), 32'd0);
        w = 0;
        while (!usr_ack && w < 200) begin @(negedge clk); w++; end
        usr_req = 1'b0; usr_pending = 1'b0;
        check("R12 served while disabled", {15'd0, usr_ok, usr_rdata}, {15'd0, 1'b1, 16'hA22B});
        @(negedge clk);
        check("R12 idle back after service", 32'(idle), 32'd1);

        // R10/R8: re-enable resumes after the last polled address.
        scan_en = 1'b1;
        w = 0;
        while (!eng_req && w < 50) begin @(negedge clk); w++; end
        check("R8 R10 resume address", {22'd0, eng_phy, eng_reg}, {22'd0, last + 5'd1, 5'd1});
        wait_scans(4);
        check("R2 R8 poll sequence", 32'(seq_err), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule